// File: doc/BRIEF.md
# Dual-Stream Repetition Health Tester

This block watches two raw single-bit noise streams that are sampled together, one 2-bit sample per accepted sampling cycle. It runs continuous health tests on them. Each stream is checked for a run of identical bits and for a run of repeated alternating bit pairs. The two streams are also checked jointly for both kinds of run at the same time. Each of these checks has its own limit, so there are four limits for six counters. When any limit is exceeded, the block raises a live seed-error status, latches a sticky seed-error flag, and tells the downstream generator to stop and drop samples. The testing goes on while the error holds, and the live status drops again as soon as no counter is above its limit.

Software clears the sticky flag by writing a 0 to it. Writing a 1 does nothing. If the error first appears while the generator reports that it is still initializing, the block sends a one-cycle request to restart initialization.

Pattern runs are counted in non-overlapping pairs, taken from the first valid sample after enable: samples 1 and 2 form a pair, then 3 and 4, and so on. A pair is alternating when its two bits differ (01 or 10). The pattern count grows by one when a completed pair is alternating and equal to the stream's previous pair. It restarts at 1 for a new alternating pair and goes to 0 on a non-alternating pair. A constant-run count is the number of consecutive valid samples with the same bit. A joint count is the smaller of the two per-stream counts of the same kind.

Top module: `dual_rep_health`

## Requirements
- R1: The error rises when either stream alone shows more than 64 consecutive identical bits: it is clear after the 64th identical sample and set after the 65th.
- R2: The error rises when either stream alone shows more than 32 consecutive repeats of the same alternating pair (01 or 10), counted in non-overlapping pairs from enable.
- R3: The error rises when both streams at once show more than 32 consecutive repeated bits (joint run = smaller of the two run lengths).
- R4: The error rises when both streams at once show more than 16 consecutive repeated alternating pairs (joint count = smaller of the two pattern counts).
- R5: `seed_err_live` and `seed_err_sticky` rise on the same clock edge, one edge after the failing sample. `drop_samples` is equal to `seed_err_live`.
- R6: A cycle with `flag_wr`=1 and `flag_wdata`=0 clears the sticky flag, unless an error is present on that edge, in which case setting wins. `flag_wr`=1 with `flag_wdata`=1 leaves the flag unchanged.
- R7: The live status returns to 0 on the edge after the sample that breaks every failing run. The sticky flag stays 1.
- R8: `init_restart` pulses for exactly one cycle, together with the live status rising, when the error starts while `init_busy` is 1. There is no pulse while an error persists or when `init_busy` is 0.
- R9: `gen_en`=0 clears all counters and the pair alignment, and the live status goes to 0 on the next edge. After re-enable, runs count from the first new sample.
- R10: Counters saturate at their maximum and never wrap. A run far longer than the counter range keeps the error set.
- R11: Cycles with `smp_vld`=0 neither extend nor break any run, whatever `smp_bits` holds.
- R12: After reset, all outputs are 0 and the sticky flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_en | input | 1 | Generator enable; low clears all run state |
| smp_vld | input | 1 | Marks a cycle that carries a new 2-bit sample |
| smp_bits | input | 2 | Raw sample, bit 0 = stream 0, bit 1 = stream 1 |
| init_busy | input | 1 | Generator is still in its initialization sequence |
| flag_wr | input | 1 | Write strobe for the sticky seed-error flag |
| flag_wdata | input | 1 | Write value; 0 clears, 1 has no effect |
| seed_err_live | output | 1 | A faulty sequence is currently detected |
| seed_err_sticky | output | 1 | A faulty sequence has been detected since the last clear |
| drop_samples | output | 1 | Downstream must stop producing output and drop samples |
| init_restart | output | 1 | One-cycle request to restart initialization |

## Verification
A wrong counter or lost pair alignment shows at the ports as a live error that comes one sample early or late. It can also show as one that never comes, or one that stays up after the breaking sample. Every such fault becomes visible one edge after the sample concerned. A sticky-flag or restart fault shows within one edge of the write or the error start. For this reason the reference model derives run lengths from the full sample history and compares all four outputs on every cycle. Targeted sequences sit exactly one sample below and one sample above each of the four limits, and a long stuck run crosses the counter's saturation point.

// File: rtl/rep_health_pkg.sv
package rep_health_pkg;

  // Per-sample events produced by one stream tracker.
  typedef struct packed {
    logic rep;        // accepted sample equals the previous one
    logic pair_done;  // this sample completed a pair
    logic pair_alt;   // completed pair is 01 or 10
    logic pair_rep;   // completed alternating pair equals the previous pair
  } strm_evt_t;

endpackage

// File: rtl/rep_stream_track.sv
module rep_stream_track
  import rep_health_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             smp_vld,
  input  logic             bit_i,
  output logic [CNT_W-1:0] run_nxt,
  output logic [CNT_W-1:0] pat_nxt,
  output strm_evt_t        evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + ONE;
  endfunction

  logic             have_prev_q, prev_q;
  logic             phase_q, first_q;
  logic             have_pair_q;
  logic [1:0]       ppair_q;
  logic [CNT_W-1:0] run_q, pat_q;
  logic [1:0]       pair;

  assign pair = {first_q, bit_i};

  always_comb begin
    run_nxt = run_q;
    pat_nxt = pat_q;
    evt     = '0;
    if (!gen_en) begin
      run_nxt = '0;
      pat_nxt = '0;
    end else if (smp_vld) begin
      evt.rep = have_prev_q && (bit_i == prev_q);
      run_nxt = evt.rep ? sat_inc(run_q) : ONE;
      if (phase_q) begin
        evt.pair_done = 1'b1;
        evt.pair_alt  = first_q ^ bit_i;
        evt.pair_rep  = evt.pair_alt && have_pair_q && (pair == ppair_q);
        if (!evt.pair_alt)     pat_nxt = '0;
        else if (evt.pair_rep) pat_nxt = sat_inc(pat_q);
        else                   pat_nxt = ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_q      <= 1'b0;
      phase_q     <= 1'b0;
      first_q     <= 1'b0;
      have_pair_q <= 1'b0;
      ppair_q     <= 2'b00;
      run_q       <= '0;
      pat_q       <= '0;
    end else begin
      run_q <= run_nxt;
      pat_q <= pat_nxt;
      if (!gen_en) begin
        have_prev_q <= 1'b0;
        phase_q     <= 1'b0;
        have_pair_q <= 1'b0;
      end else if (smp_vld) begin
        have_prev_q <= 1'b1;
        prev_q      <= bit_i;
        phase_q     <= ~phase_q;
        if (!phase_q) begin
          first_q <= bit_i;
        end else begin
          ppair_q     <= pair;
          have_pair_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rep_joint_track.sv
module rep_joint_track
  import rep_health_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic             smp_vld,
  input  strm_evt_t        evt_a,
  input  strm_evt_t        evt_b,
  output logic [CNT_W-1:0] jrun_q,
  output logic [CNT_W-1:0] jrun_nxt,
  output logic [CNT_W-1:0] jpat_nxt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + ONE;
  endfunction

  logic [CNT_W-1:0] jpat_q;
  logic             both_alt, both_prep;

  assign both_alt  = evt_a.pair_alt & evt_b.pair_alt;
  assign both_prep = evt_a.pair_rep & evt_b.pair_rep;

  always_comb begin
    jrun_nxt = jrun_q;
    jpat_nxt = jpat_q;
    if (!gen_en) begin
      jrun_nxt = '0;
      jpat_nxt = '0;
    end else if (smp_vld) begin
      jrun_nxt = (evt_a.rep & evt_b.rep) ? sat_inc(jrun_q) : ONE;
      if (evt_a.pair_done) begin
        if (!both_alt)      jpat_nxt = '0;
        else if (both_prep) jpat_nxt = sat_inc(jpat_q);
        else                jpat_nxt = ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jrun_q <= '0;
      jpat_q <= '0;
    end else begin
      jrun_q <= jrun_nxt;
      jpat_q <= jpat_nxt;
    end
  end

endmodule

// File: rtl/rep_status_flags.sv
module rep_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_nxt,
  input  logic init_busy,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic live_q,
  output logic sticky_q,
  output logic restart_q
);

  logic clr_req;
  assign clr_req = flag_wr & ~flag_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= 1'b0;
      sticky_q  <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      live_q    <= fail_nxt;
      sticky_q  <= fail_nxt | (sticky_q & ~clr_req);
      restart_q <= fail_nxt & ~live_q & init_busy;
    end
  end

endmodule

// File: rtl/dual_rep_health.sv
module dual_rep_health
  import rep_health_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int SOLO_RUN_LIM = 64,
  parameter int SOLO_PAT_LIM = 32,
  parameter int DUO_RUN_LIM  = 32,
  parameter int DUO_PAT_LIM  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gen_en,
  input  logic       smp_vld,
  input  logic [1:0] smp_bits,
  input  logic       init_busy,
  input  logic       flag_wr,
  input  logic       flag_wdata,
  output logic       seed_err_live,
  output logic       seed_err_sticky,
  output logic       drop_samples,
  output logic       init_restart
);

  localparam int NSTR = 2;
  localparam logic [CNT_W-1:0] L_SR = CNT_W'(SOLO_RUN_LIM);
  localparam logic [CNT_W-1:0] L_SP = CNT_W'(SOLO_PAT_LIM);
  localparam logic [CNT_W-1:0] L_DR = CNT_W'(DUO_RUN_LIM);
  localparam logic [CNT_W-1:0] L_DP = CNT_W'(DUO_PAT_LIM);

  function automatic logic above(input logic [CNT_W-1:0] v,
                                 input logic [CNT_W-1:0] lim);
    return v > lim;
  endfunction

  strm_evt_t        evt     [NSTR];
  logic [CNT_W-1:0] run_nxt [NSTR];
  logic [CNT_W-1:0] pat_nxt [NSTR];
  logic [NSTR-1:0]  solo_fail;
  logic [CNT_W-1:0] jrun_q, jrun_nxt, jpat_nxt;
  logic             duo_fail, fail_nxt, both_rep;

  for (genvar g = 0; g < NSTR; g++) begin : g_strm
    rep_stream_track #(.CNT_W(CNT_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .gen_en  (gen_en),
      .smp_vld (smp_vld),
      .bit_i   (smp_bits[g]),
      .run_nxt (run_nxt[g]),
      .pat_nxt (pat_nxt[g]),
      .evt     (evt[g])
    );
    assign solo_fail[g] = above(run_nxt[g], L_SR) | above(pat_nxt[g], L_SP);
  end

  rep_joint_track #(.CNT_W(CNT_W)) u_joint (
    .clk      (clk),
    .rst_n    (rst_n),
    .gen_en   (gen_en),
    .smp_vld  (smp_vld),
    .evt_a    (evt[0]),
    .evt_b    (evt[1]),
    .jrun_q   (jrun_q),
    .jrun_nxt (jrun_nxt),
    .jpat_nxt (jpat_nxt)
  );

  assign both_rep = evt[0].rep & evt[1].rep;
  assign duo_fail = above(jrun_nxt, L_DR) | above(jpat_nxt, L_DP);
  assign fail_nxt = (|solo_fail) | duo_fail;

  rep_status_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .fail_nxt   (fail_nxt),
    .init_busy  (init_busy),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .live_q     (seed_err_live),
    .sticky_q   (seed_err_sticky),
    .restart_q  (init_restart)
  );

  assign drop_samples = seed_err_live;

endmodule

// File: rtl/rep_health_chk.sv
module rep_health_chk #(
  parameter int CNT_W       = 8,
  parameter int DUO_RUN_LIM = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             smp_vld,
  input logic             flag_wr,
  input logic             flag_wdata,
  input logic             init_busy,
  input logic             live,
  input logic             sticky,
  input logic             restart,
  input logic             both_rep,
  input logic [CNT_W-1:0] jrun
);

  localparam logic [CNT_W-1:0] L_DR = CNT_W'(DUO_RUN_LIM);

  AST_JOINT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en && smp_vld && both_rep && (jrun == L_DR) |=> live); // R3

  AST_STICKY_WITH_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> sticky); // R5

  AST_CLEAR_FOLLOWS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr && !flag_wdata |=> (sticky == live)); // R6

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sticky && !(flag_wr && !flag_wdata) |=> sticky); // R6

  AST_RESTART_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> live && !$past(live) && $past(init_busy)); // R8

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !live && !restart); // R9

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en && smp_vld && (jrun != '0) |=> (jrun != '0)); // R10

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en && smp_vld && both_rep && (&jrun) |=> (&jrun)); // R10

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en && !smp_vld |=> $stable(live)); // R11

endmodule

bind dual_rep_health rep_health_chk #(.CNT_W(CNT_W), .DUO_RUN_LIM(DUO_RUN_LIM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .gen_en     (gen_en),
  .smp_vld    (smp_vld),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .init_busy  (init_busy),
  .live       (seed_err_live),
  .sticky     (seed_err_sticky),
  .restart    (init_restart),
  .both_rep   (both_rep),
  .jrun       (jrun_q)
);

// File: tb/tb_dual_rep_health.sv
`timescale 1ns/1ps
module tb_dual_rep_health;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gen_en = 1'b0, smp_vld = 1'b0, init_busy = 1'b0;
  logic       flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [1:0] smp_bits = 2'b00;
  logic       seed_err_live, seed_err_sticky, drop_samples, init_restart;

  always #2 clk = ~clk;

  dual_rep_health dut (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .smp_vld(smp_vld),
    .smp_bits(smp_bits), .init_busy(init_busy), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .seed_err_live(seed_err_live),
    .seed_err_sticky(seed_err_sticky), .drop_samples(drop_samples),
    .init_restart(init_restart)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_req = "R12";

  // reference model state: full sample history since enable
  bit q0[$];
  bit q1[$];
  bit m_live = 0, m_sticky = 0, m_restart = 0;

  function automatic int run_len(ref bit q[$]);
    int n = q.size();
    int c;
    if (n == 0) return 0;
    c = 1;
    for (int i = n - 2; i >= 0; i--) begin
      if (q[i] != q[n-1] || c >= 255) break;
      c++;
    end
    return c;
  endfunction

  function automatic int pat_len(ref bit q[$]);
    int m = q.size() - (q.size() % 2);
    int c;
    bit a, b;
    if (m < 2) return 0;
    a = q[m-2]; b = q[m-1];
    if (a == b) return 0;
    c = 1;
    for (int k = m - 4; k >= 0; k -= 2) begin
      if (q[k] != a || q[k+1] != b || c >= 255) break;
      c++;
    end
    return c;
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_update();
    int r0, r1, p0, p1;
    bit fail;
    if (!gen_en) begin
      q0.delete(); q1.delete();
    end else if (smp_vld) begin
      q0.push_back(smp_bits[0]); q1.push_back(smp_bits[1]);
    end
    r0 = run_len(q0); r1 = run_len(q1);
    p0 = pat_len(q0); p1 = pat_len(q1);
    fail = (r0 > 64) || (r1 > 64) || (p0 > 32) || (p1 > 32) ||
           (imin(r0, r1) > 32) || (imin(p0, p1) > 16);
    m_restart = fail && !m_live && init_busy;
    m_sticky  = fail || (m_sticky && !(flag_wr && !flag_wdata));
    m_live    = fail;
  endtask

  task automatic drive(bit en, bit vld, bit b0, bit b1, bit wr = 0, bit wd = 0);
    gen_en = en; smp_vld = vld; smp_bits = {b1, b0};
    flag_wr = wr; flag_wdata = wd;
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk(cur_req, "live", seed_err_live, m_live);
    chk(cur_req, "sticky", seed_err_sticky, m_sticky);
    chk("R5", "drop", drop_samples, m_live);
    chk(cur_req, "restart", init_restart, m_restart);
  endtask

  // mode: 0 const0, 1 const1, 2 "01" pairs, 3 "10" pairs, 4 "0011" blocks
  function automatic bit gen_bit(int mode, int i);
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return bit'(i % 2);
      3: return bit'(1 - (i % 2));
      default: return bit'((i / 2) % 2);
    endcase
  endfunction

  task automatic run_seq(int n, int m0, int m1);
    for (int i = 0; i < n; i++) drive(1, 1, gen_bit(m0, i), gen_bit(m1, i));
  endtask

  task automatic restart_en();
    drive(0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "live", seed_err_live, 0);
    chk("R12", "sticky", seed_err_sticky, 0);
    chk("R12", "restart", init_restart, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: stream 0 stuck at 1
    cur_req = "R1";
    run_seq(64, 1, 4);
    chk("R1", "live after 64", seed_err_live, 0);
    run_seq(1, 1, 4);
    chk("R1", "live after 65", seed_err_live, 1);
    chk("R5", "sticky with live", seed_err_sticky, 1);
    chk("R5", "drop with live", drop_samples, 1);

    // R6: write 1 ignored, write 0 during error loses to set
    cur_req = "R6";
    drive(1, 1, 1, 0, 1, 1);
    chk("R6", "sticky after w1", seed_err_sticky, 1);
    drive(1, 1, 1, 1, 1, 0);
    chk("R6", "sticky w0 during error", seed_err_sticky, 1);

    // R7: break the run
    cur_req = "R7";
    drive(1, 1, 0, 0);
    chk("R7", "live after break", seed_err_live, 0);
    chk("R7", "sticky kept", seed_err_sticky, 1);
    cur_req = "R6";
    drive(1, 0, 1, 1, 1, 1);
    chk("R6", "sticky after w1 idle", seed_err_sticky, 1);
    drive(1, 0, 1, 1, 1, 0);
    chk("R6", "sticky after w0", seed_err_sticky, 0);

    // R2: stream 0 repeats 01 pairs
    cur_req = "R2";
    restart_en();
    run_seq(64, 2, 4);
    chk("R2", "live after 32 pairs", seed_err_live, 0);
    run_seq(1, 2, 4);
    chk("R2", "live mid pair", seed_err_live, 0);
    drive(1, 1, 1, 1);
    chk("R2", "live after 33 pairs", seed_err_live, 1);

    // R9: disable clears an active error
    cur_req = "R9";
    restart_en();
    chk("R9", "live after disable", seed_err_live, 0);

    // R3: both stuck
    cur_req = "R3";
    run_seq(32, 1, 0);
    chk("R3", "live after 32 joint", seed_err_live, 0);
    run_seq(1, 1, 0);
    chk("R3", "live after 33 joint", seed_err_live, 1);

    // R4: both alternating
    cur_req = "R4";
    restart_en();
    run_seq(32, 2, 3);
    chk("R4", "live after 16 joint pairs", seed_err_live, 0);
    run_seq(2, 2, 3);
    chk("R4", "live after 17 joint pairs", seed_err_live, 1);

    // R8: restart request during init
    cur_req = "R8";
    restart_en();
    init_busy = 1'b1;
    run_seq(32, 1, 0);
    chk("R8", "no restart yet", init_restart, 0);
    run_seq(1, 1, 0);
    chk("R8", "restart pulse", init_restart, 1);
    run_seq(1, 1, 0);
    chk("R8", "pulse one cycle", init_restart, 0);
    init_busy = 1'b0;
    restart_en();
    run_seq(33, 1, 0);
    chk("R8", "no restart outside init", init_restart, 0);

    // R9: counting restarts from zero after re-enable
    cur_req = "R9";
    restart_en();
    run_seq(64, 1, 4);
    chk("R9", "fresh count 64", seed_err_live, 0);

    // R10: saturation
    cur_req = "R10";
    restart_en();
    run_seq(300, 1, 1);
    chk("R10", "live after 300", seed_err_live, 1);
    drive(1, 1, 0, 1);
    chk("R10", "stream1 still stuck", seed_err_live, 1);
    drive(1, 1, 0, 0);
    chk("R10", "both broken", seed_err_live, 0);

    // R11: idle cycles do not touch runs
    cur_req = "R11";
    restart_en();
    run_seq(60, 1, 4);
    for (int i = 0; i < 10; i++) drive(1, 0, bit'(i % 2), bit'(i % 2));
    run_seq(4, 1, 4);
    chk("R11", "live after 64 valid", seed_err_live, 0);
    run_seq(1, 1, 4);
    chk("R11", "live after 65 valid", seed_err_live, 1);

    // mixed random traffic against the model
    cur_req = "R5";
    restart_en();
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      init_busy = lfsr[7];
      if (lfsr[11:8] == 4'h0) drive(0, lfsr[1], lfsr[2], lfsr[3]);
      else if (lfsr[6:5] == 2'b00) drive(1, 0, lfsr[2], lfsr[3], lfsr[4], lfsr[9]);
      else if (lfsr[14]) drive(1, 1, 1'b1, lfsr[3], lfsr[4], lfsr[9]);
      else drive(1, 1, lfsr[0], lfsr[3], lfsr[4], lfsr[9]);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule